// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block is the 32-bit interrupt control and status word of a seven-channel DMA engine. Software writes it to set per-channel completion enables, a global enable, a forced-interrupt (bus error) bit and six general-purpose bits. The same write acknowledges channel completion flags by writing ones to them. The transfer engines report the end of a transfer with one-cycle pulses on `done_i`. A pulse latches a flag only when that channel is enabled.

From these fields the block derives a master flag. The master flag is set when the global enable is on and any channel flag is set, or when the force bit is on. It is re-evaluated on every write and every accepted completion pulse. When the master flag goes from 0 to 1, the block sends a single-cycle request on `irq_pulse` to the system interrupt controller. It sends no further request while the flag stays high.

Bit layout: bits 5:0 general purpose, bits 14:6 read as zero, bit 15 force, bits 22:16 channel enables (bit 16+n for channel n), bit 23 global enable, bits 30:24 channel flags (bit 24+n for channel n), bit 31 master flag.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00000000 and `irq_pulse` is 0.
- R2: A write stores bits 5:0, 15 and 23:16 of `wr_data` exactly. Bits 14:6 always read as zero.
- R3: Writing 1 to flag bit 24+n clears channel n's flag. Writing 0 to it leaves the flag unchanged.
- R4: Writing 1 to bits 31:24 never sets a flag or the master bit.
- R5: A pulse on `done_i[n]` sets flag bit 24+n only if enable bit 16+n is set. If a write happens in the same cycle, the enable value that write stores is used.
- R6: Bit 31 equals (bit 23 AND any of bits 30:24) OR bit 15. It is visible on `rd_data` one cycle after the write or pulse that caused it.
- R7: `irq_pulse` is high for exactly one cycle, in the same cycle that bit 31 first reads 1 after having been 0. It stays low while bit 31 remains 1.
- R8: If a completion pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write value |
| done_i | input | 7 | Per-channel completion pulses |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to the interrupt controller |

## Verification
The assertions assume that `done_i` and `wr_en` are sampled only at the rising edge. They also assume that the master flag and the channel fields are driven from the same next-state values, so the register and the derived flag can never disagree for a cycle. The stimulus changes inputs only at the falling edge and holds them for one full cycle. It includes cases where a pulse and a write arrive in the same cycle. It also includes pulses to disabled channels, so the gating and the priority of setting over clearing are both exercised.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int DW         = 32;
  localparam int AUX_W      = 6;
  localparam int FORCE_BIT  = 15;
  localparam int EN_LSB     = 16;
  localparam int GE_BIT     = 23;
  localparam int FLAG_LSB   = 24;
  localparam int MASTER_BIT = 31;

  // Next value of one flag: a completion that is allowed wins over a clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // Master flag from the fields that will be stored this cycle.
  function automatic logic master_of(input logic ge, input logic any_flag, input logic force_b);
    return (ge & any_flag) | force_b;
  endfunction
endpackage

// File: rtl/dicr_ctrl_regs.sv
module dicr_ctrl_regs
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [AUX_W-1:0]  aux_q,
  output logic              force_q,
  output logic [NUM_CH-1:0] en_q,
  output logic              ge_q,
  output logic              force_nx,
  output logic [NUM_CH-1:0] en_nx,
  output logic              ge_nx
);
  logic [AUX_W-1:0] aux_nx;

  always_comb begin
    aux_nx   = wr_en ? wr_data[AUX_W-1:0]       : aux_q;
    force_nx = wr_en ? wr_data[FORCE_BIT]        : force_q;
    en_nx    = wr_en ? wr_data[EN_LSB +: NUM_CH] : en_q;
    ge_nx    = wr_en ? wr_data[GE_BIT]           : ge_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_q   <= '0;
      force_q <= 1'b0;
      en_q    <= '0;
      ge_q    <= 1'b0;
    end else begin
      aux_q   <= aux_nx;
      force_q <= force_nx;
      en_q    <= en_nx;
      ge_q    <= ge_nx;
    end
  end

  // R2: with no write the stored control fields hold their value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q) && $stable(ge_q) && $stable(force_q) && $stable(aux_q));
endmodule

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] en_nx,
  output logic [NUM_CH-1:0] flag_q,
  output logic [NUM_CH-1:0] flag_nx
);
  logic [NUM_CH-1:0] set_ev;
  logic [NUM_CH-1:0] clr_ev;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign set_ev[n]  = done_i[n] & en_nx[n];
    assign clr_ev[n]  = wr_en & clr_bits[n];
    assign flag_nx[n] = flag_next(flag_q[n], clr_ev[n], set_ev[n]);

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[n] <= 1'b0;
      else        flag_q[n] <= flag_nx[n];
    end

    // R5: a flag cannot appear without an enabled completion
    p_gated_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[n] && !(done_i[n] && en_nx[n])) |=> !flag_q[n]);
    // R3: an acknowledge with no competing completion clears the flag
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_bits[n] && !done_i[n]) |=> !flag_q[n]);
    // R8: an accepted completion always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[n] && en_nx[n]) |=> flag_q[n]);
  end
endmodule

// File: rtl/dicr_master.sv
module dicr_master
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ge_nx,
  input  logic              force_nx,
  input  logic [NUM_CH-1:0] flag_nx,
  output logic              master_q,
  output logic              irq_pulse
);
  logic master_nx;
  logic master_rise;

  assign master_nx   = master_of(ge_nx, |flag_nx, force_nx);
  assign master_rise = master_nx & ~master_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      master_q  <= master_nx;
      irq_pulse <= master_rise;
    end
  end

  // R7: a request only accompanies a fresh 0-to-1 of the master flag
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> master_q && !$past(master_q));
  // R7: never two requests back to back
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [DW-1:0]     rd_data,
  output logic              irq_pulse
);
  logic [AUX_W-1:0]  aux_q;
  logic              force_q, ge_q, force_nx, ge_nx, master_q;
  logic [NUM_CH-1:0] en_q, en_nx, flag_q, flag_nx;

  dicr_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .aux_q(aux_q), .force_q(force_q), .en_q(en_q), .ge_q(ge_q),
    .force_nx(force_nx), .en_nx(en_nx), .ge_nx(ge_nx)
  );

  dicr_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .clr_bits(wr_data[FLAG_LSB +: NUM_CH]), .done_i(done_i), .en_nx(en_nx),
    .flag_q(flag_q), .flag_nx(flag_nx)
  );

  dicr_master #(.NUM_CH(NUM_CH)) u_master (
    .clk(clk), .rst_n(rst_n), .ge_nx(ge_nx), .force_nx(force_nx),
    .flag_nx(flag_nx), .master_q(master_q), .irq_pulse(irq_pulse)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[AUX_W-1:0]          = aux_q;
    rd_data[FORCE_BIT]          = force_q;
    rd_data[EN_LSB +: NUM_CH]   = en_q;
    rd_data[GE_BIT]             = ge_q;
    rd_data[FLAG_LSB +: NUM_CH] = flag_q;
    rd_data[MASTER_BIT]         = master_q;
  end

  // R6: stored master bit agrees with the stored fields it is derived from
  p_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    master_q == ((ge_q && (|flag_q)) || force_q));
endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  done_i = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                    .done_i(done_i), .rd_data(rd_data), .irq_pulse(irq_pulse));

  typedef struct packed {
    logic        we;
    logic [31:0] wd;
    logic [6:0]  done;
    logic [31:0] rd;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'hFFFF_FFFF, 7'h00, 32'h80FF_803F, 1'b1, 4'd2}, // R2 R4 R7 force raises master
    '{1'b0, 32'h0,         7'h00, 32'h80FF_803F, 1'b0, 4'd7}, // R7 no repeat
    '{1'b1, 32'h0,         7'h00, 32'h0000_0000, 1'b0, 4'd6}, // R6 master falls
    '{1'b1, 32'h00FF_0000, 7'h00, 32'h00FF_0000, 1'b0, 4'd2}, // R2 enables + global
    '{1'b0, 32'h0,         7'h01, 32'h81FF_0000, 1'b1, 4'd5}, // R5 R7 ch0 completes
    '{1'b0, 32'h0,         7'h40, 32'hC1FF_0000, 1'b0, 4'd7}, // R7 second flag, no pulse
    '{1'b1, 32'h01FF_0000, 7'h00, 32'hC0FF_0000, 1'b0, 4'd3}, // R3 clear ch0 only
    '{1'b1, 32'h40FF_0000, 7'h00, 32'h00FF_0000, 1'b0, 4'd3}, // R3 R6 clear ch6
    '{1'b1, 32'h007F_0000, 7'h00, 32'h007F_0000, 1'b0, 4'd2}, // R2 global off
    '{1'b0, 32'h0,         7'h04, 32'h047F_0000, 1'b0, 4'd6}, // R6 flag without global
    '{1'b1, 32'h00FF_0000, 7'h00, 32'h84FF_0000, 1'b1, 4'd6}, // R6 R3 global on, flag kept
    '{1'b1, 32'h04FF_0000, 7'h04, 32'h84FF_0000, 1'b0, 4'd8}, // R8 set beats clear
    '{1'b1, 32'h04FF_0000, 7'h00, 32'h00FF_0000, 1'b0, 4'd3}, // R3 clear ch2
    '{1'b1, 32'h0000_003F, 7'h00, 32'h0000_003F, 1'b0, 4'd2}, // R2 aux bits
    '{1'b0, 32'h0,         7'h7F, 32'h0000_003F, 1'b0, 4'd5}, // R5 all disabled
    '{1'b1, 32'h0000_7FC0, 7'h00, 32'h0000_0000, 1'b0, 4'd2}, // R2 gap bits read zero
    '{1'b1, 32'h0001_0000, 7'h03, 32'h0101_0000, 1'b0, 4'd5}, // R5 new enable used
    '{1'b1, 32'h0001_8000, 7'h00, 32'h8101_8000, 1'b1, 4'd6}, // R6 force
    '{1'b1, 32'hFE00_0000, 7'h00, 32'h0100_0000, 1'b0, 4'd4}, // R4 bit31 not writable
    '{1'b1, 32'h7F80_0000, 7'h00, 32'h0080_0000, 1'b0, 4'd3}  // R3 clear all
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [31:0] wd, input logic [6:0] dn);
    wr_en = we; wr_data = wd; done_i = dn;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; done_i = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 32'h0, 1, "R1 reset rd_data");
    check({31'b0, irq_pulse}, 32'h0, 1, "R1 reset irq");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 32'h0, 1, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].we, VEC[i].wd, VEC[i].done);
      check(rd_data, VEC[i].rd, int'(VEC[i].req), $sformatf("vec %0d rd_data", i));
      check({31'b0, irq_pulse}, {31'b0, VEC[i].irq}, int'(VEC[i].req), $sformatf("vec %0d irq", i));
    end

    // R7: idle after the last vector, no request
    cycle(1'b0, 32'h0, 7'h00);
    check({31'b0, irq_pulse}, 32'h0, 7, "R7 idle");

    // R1: reset in the middle of activity
    cycle(1'b1, 32'h00FF_8000, 7'h7F);
    check(rd_data, 32'hFFFF_8000, 6, "R6 all flags and force");
    rst_n = 1'b0;
    @(posedge clk); #1; @(negedge clk);
    check(rd_data, 32'h0, 1, "R1 mid-run reset rd_data");
    check({31'b0, irq_pulse}, 32'h0, 1, "R1 mid-run reset irq");
    rst_n = 1'b1;
    cycle(1'b0, 32'h0, 7'h00);
    check({31'b0, irq_pulse}, 32'h0, 1, "R1 no pulse after reset");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule